// File: doc/BRIEF.md
# Vector Port Distribution Mapper

This block takes one wide, contiguous vector write (by default eight 16-bit words, as fetched from memory or a vector register) and spreads its elements over the scalar input FIFOs of a compute array. A small programmable map holds one entry per element position. Each entry either names the destination port or marks the element as unused. Interleaved or strided layouts can then feed separate ports from one write. One example is a four-word record of which only three fields are consumed.

A walker takes the captured vector one element per cycle, in ascending position order. It pushes each mapped element into its port. It drops skipped elements and waits whenever the target FIFO reports full. Elements bound for the same port therefore arrive there in their original order. A new vector is taken only after the current one has been fully handed out, and a one-cycle done pulse marks that point. The map is loaded through a separate write port and is frozen while a vector is in flight. The FIFOs themselves sit outside the block; only their push strobes, shared data bus and full flags cross the boundary.

Top module: `vecmap_distributor`

## Requirements
- R1: After reset `vec_ready` is 1, `port_push` is 0 and `vec_done` is 0. Every map entry resets to the skip code, so a vector sent before any map write is dropped whole with no push.
- R2: A map entry is 3 bits. Bit 2 set means skip; with bit 2 clear, bits 1:0 give the destination port index 0..3. `cfg_we` writes `cfg_entry` into the entry for position `cfg_idx` at the clock edge.
- R3: Element i of a vector is `vec_data[i*DATA_W +: DATA_W]`. Elements are handled in ascending i. Each element with a non-skip entry is pushed exactly once, to the mapped port, with `port_data` equal to the element. At most one push happens per cycle, so each port sees its elements in position order.
- R4: A skipped element produces no push and takes exactly one cycle. Without backpressure, the last element of a vector is handled ELEMS cycles after the accepting clock edge.
- R5: No push is made to a port whose `port_full` is high in that cycle. The element waits, and later elements are not overtaken.
- R6: `vec_done` is high for one cycle, in the cycle in which the last element is pushed or skipped. `vec_ready` is high in the following cycle.
- R7: A vector is accepted at an edge where `vec_valid` and `vec_ready` are both 1. `vec_ready` then stays 0 until after `vec_done`, and `vec_valid` has no effect in that period.
- R8: A map write made while a vector is in flight, or in the same cycle a vector is accepted, is dropped. The vector in flight and every later vector use the map as it stood before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Map write strobe |
| cfg_idx | input | IDX_W (3) | Element position of the map entry to write |
| cfg_entry | input | 3 | Map entry value: bit 2 skip, bits 1:0 port |
| vec_valid | input | 1 | Vector offered |
| vec_data | input | ELEMS*DATA_W (128) | Contiguous vector, element 0 in the low bits |
| vec_ready | output | 1 | Mapper idle; a vector is taken this cycle if offered |
| port_full | input | NPORTS (4) | Full flag of each destination FIFO |
| port_push | output | NPORTS (4) | Push strobe, one bit per destination FIFO |
| port_data | output | DATA_W (16) | Element being pushed, shared by all FIFOs |
| vec_done | output | 1 | Last element of the current vector handled |

## Verification
Two activities can collide in one cycle: a map write and a vector acceptance, and a map write and an ongoing distribution. The bench holds `cfg_we` high with an entry that would move element 0 to another port. It does so from the accepting cycle through the whole distribution, under rotating backpressure. It then judges the pushed stream against the unmodified map. A further vector sent without reprogramming must follow the old map too, which shows at the ports that the write never landed. The main sweep covers several maps (strided with skips, round-robin, single port, computed patterns, all-skip) against three backpressure patterns, and checks port, data, order, cycle count and the done pulse.

// File: rtl/vm_pkg.sv
package vm_pkg;

  localparam int ENTRY_W = 3;

  typedef logic [ENTRY_W-1:0] map_entry_t;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } walk_state_e;

  localparam map_entry_t ENTRY_SKIP = 3'b100;

  function automatic logic entry_skip(input map_entry_t e);
    return e[2];
  endfunction

  function automatic logic [1:0] entry_port(input map_entry_t e);
    return e[1:0];
  endfunction

endpackage

// File: rtl/vm_map_store.sv
module vm_map_store
  import vm_pkg::*;
#(
  parameter int ELEMS = 8,
  parameter int IDX_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  map_entry_t       wr_entry,
  input  logic             busy,
  input  logic             accept,
  input  logic [IDX_W-1:0] rd_idx,
  output map_entry_t       rd_entry,
  output logic             wr_take
);

  logic [ELEMS-1:0][ENTRY_W-1:0] map_q;
  logic idx_ok;

  generate
    if ((1 << IDX_W) == ELEMS) begin : g_pow2
      assign idx_ok = 1'b1;
    end else begin : g_npow2
      assign idx_ok = (int'(wr_idx) < ELEMS);
    end
  endgenerate

  // writes land only while no vector is being taken or walked
  assign wr_take  = wr_en && !busy && !accept && idx_ok;
  assign rd_entry = map_q[rd_idx];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < ELEMS; i++) map_q[i] <= ENTRY_SKIP;
    end else if (wr_take) begin
      map_q[wr_idx] <= wr_entry;
    end
  end

  // R8: map frozen from acceptance to the end of distribution
  p_map_frozen_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy || accept) |=> $stable(map_q));

endmodule

// File: rtl/vm_walker.sv
module vm_walker
  import vm_pkg::*;
#(
  parameter int ELEMS  = 8,
  parameter int DATA_W = 16,
  parameter int IDX_W  = 3
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    vec_valid,
  input  logic [ELEMS*DATA_W-1:0] vec_data,
  input  logic                    advance,
  output logic                    vec_ready,
  output logic                    accept,
  output logic                    busy,
  output logic [IDX_W-1:0]        idx,
  output logic [DATA_W-1:0]       elem,
  output logic                    done
);

  localparam logic [IDX_W-1:0] LAST = IDX_W'(ELEMS - 1);

  walk_state_e             state_q;
  logic [IDX_W-1:0]        idx_q;
  logic [ELEMS*DATA_W-1:0] data_q;
  logic                    at_last;

  function automatic logic [DATA_W-1:0] pick_elem(
    input logic [ELEMS*DATA_W-1:0] v, input logic [IDX_W-1:0] i);
    return v[int'(i)*DATA_W +: DATA_W];
  endfunction

  assign busy      = (state_q == ST_RUN);
  assign vec_ready = !busy;
  assign accept    = vec_valid && vec_ready;
  assign idx       = idx_q;
  assign elem      = pick_elem(data_q, idx_q);
  assign at_last   = (idx_q == LAST);
  assign done      = busy && advance && at_last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
      data_q  <= '0;
    end else if (accept) begin
      state_q <= ST_RUN;
      idx_q   <= '0;
      data_q  <= vec_data;
    end else if (busy && advance) begin
      if (at_last) begin
        state_q <= ST_IDLE;
        idx_q   <= '0;
      end else begin
        idx_q <= idx_q + 1'b1;
      end
    end
  end

  // R7: acceptance starts a walk at element 0
  p_accept_starts_r7: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (busy && idx == '0));

  // R5: a stalled element keeps its position
  p_hold_on_stall_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !advance) |=> (busy && $stable(idx)));

  // R6: done is followed by readiness
  p_done_then_ready_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> vec_ready);

endmodule

// File: rtl/vm_steer.sv
module vm_steer
  import vm_pkg::*;
#(
  parameter int NPORTS = 4,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              busy,
  input  map_entry_t        entry,
  input  logic [DATA_W-1:0] elem,
  input  logic [NPORTS-1:0] port_full,
  output logic [NPORTS-1:0] port_push,
  output logic [DATA_W-1:0] port_data,
  output logic              advance
);

  logic [1:0] tgt;
  logic       hit;
  logic       full_sel;
  logic       drop;
  logic       fire;

  assign tgt = entry_port(entry);

  always_comb begin
    hit      = 1'b0;
    full_sel = 1'b0;
    for (int i = 0; i < NPORTS; i++) begin
      if (tgt == 2'(i)) begin
        hit      = 1'b1;
        full_sel = port_full[i];
      end
    end
  end

  // an entry naming a port that does not exist is treated as skip
  assign drop    = entry_skip(entry) || !hit;
  assign fire    = busy && !drop && !full_sel;
  assign advance = busy && (drop || !full_sel);

  always_comb begin
    for (int i = 0; i < NPORTS; i++) port_push[i] = fire && (tgt == 2'(i));
  end

  assign port_data = elem;

  // R3: one destination per cycle
  p_push_onehot_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(port_push));

  // R4: a skip entry pushes nothing and moves on
  p_skip_silent_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && entry_skip(entry)) |-> (port_push == '0 && advance));

  generate
    for (genvar p = 0; p < NPORTS; p++) begin : g_port_chk
      // R5: never push into a full FIFO
      p_no_push_full_r5: assert property (@(posedge clk) disable iff (!rst_n)
        port_push[p] |-> !port_full[p]);
    end
  endgenerate

endmodule

// File: rtl/vecmap_distributor.sv
module vecmap_distributor
  import vm_pkg::*;
#(
  parameter int ELEMS  = 8,
  parameter int DATA_W = 16,
  parameter int NPORTS = 4,
  localparam int IDX_W = (ELEMS > 1) ? $clog2(ELEMS) : 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    cfg_we,
  input  logic [IDX_W-1:0]        cfg_idx,
  input  logic [2:0]              cfg_entry,
  input  logic                    vec_valid,
  input  logic [ELEMS*DATA_W-1:0] vec_data,
  output logic                    vec_ready,
  input  logic [NPORTS-1:0]       port_full,
  output logic [NPORTS-1:0]       port_push,
  output logic [DATA_W-1:0]       port_data,
  output logic                    vec_done
);

  logic              accept;
  logic              busy;
  logic              advance;
  logic              wr_take;
  logic [IDX_W-1:0]  walk_idx;
  logic [DATA_W-1:0] walk_elem;
  map_entry_t        cur_entry;

  vm_map_store #(.ELEMS(ELEMS), .IDX_W(IDX_W)) map_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (cfg_we),
    .wr_idx   (cfg_idx),
    .wr_entry (cfg_entry),
    .busy     (busy),
    .accept   (accept),
    .rd_idx   (walk_idx),
    .rd_entry (cur_entry),
    .wr_take  (wr_take)
  );

  vm_walker #(.ELEMS(ELEMS), .DATA_W(DATA_W), .IDX_W(IDX_W)) walk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .vec_valid (vec_valid),
    .vec_data  (vec_data),
    .advance   (advance),
    .vec_ready (vec_ready),
    .accept    (accept),
    .busy      (busy),
    .idx       (walk_idx),
    .elem      (walk_elem),
    .done      (vec_done)
  );

  vm_steer #(.NPORTS(NPORTS), .DATA_W(DATA_W)) steer_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .busy      (busy),
    .entry     (cur_entry),
    .elem      (walk_elem),
    .port_full (port_full),
    .port_push (port_push),
    .port_data (port_data),
    .advance   (advance)
  );

  // R8: no map write lands while a vector is in flight
  p_no_write_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !wr_take);

  // R6: done is a single-cycle pulse
  p_done_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    vec_done |=> !vec_done);

endmodule

// File: tb/vecmap_distributor_tb.sv
module vecmap_distributor_tb_top;

  localparam int ELEMS  = 8;
  localparam int DATA_W = 16;
  localparam int NPORTS = 4;
  localparam int IDX_W  = 3;

  logic                    clk = 1'b0;
  logic                    rst_n;
  logic                    cfg_we;
  logic [IDX_W-1:0]        cfg_idx;
  logic [2:0]              cfg_entry;
  logic                    vec_valid;
  logic [ELEMS*DATA_W-1:0] vec_data;
  logic                    vec_ready;
  logic [NPORTS-1:0]       port_full;
  logic [NPORTS-1:0]       port_push;
  logic [DATA_W-1:0]       port_data;
  logic                    vec_done;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  vecmap_distributor #(.ELEMS(ELEMS), .DATA_W(DATA_W), .NPORTS(NPORTS)) dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_idx(cfg_idx),
    .cfg_entry(cfg_entry), .vec_valid(vec_valid), .vec_data(vec_data),
    .vec_ready(vec_ready), .port_full(port_full), .port_push(port_push),
    .port_data(port_data), .vec_done(vec_done)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // map patterns; entry code: bit2 skip, bits1:0 port (R2)
  function automatic logic [2:0] map_val(input int m, input int i);
    if (m == 0) return (i % 4 == 3) ? 3'b100 : 3'(i % 4);
    if (m == 1) return 3'(i % 4);
    if (m == 2) return 3'd3;
    if (m == 7) return 3'b100;
    return 3'((i * m + m) % 8);
  endfunction

  function automatic logic [DATA_W-1:0] elem_val(input int m, input int fm, input int i);
    return DATA_W'(m * 4096 + fm * 256 + i * 17 + 3);
  endfunction

  function automatic bit full_val(input int fm, input int k, input int p);
    if (fm == 1) return ((k + p) % 3 == 0);
    if (fm == 2) return (k % 5 != 0);
    return 1'b0;
  endfunction

  task automatic program_map(input int m);
    for (int i = 0; i < ELEMS; i++) begin
      @(negedge clk);
      cfg_we    = 1'b1;
      cfg_idx   = IDX_W'(i);
      cfg_entry = map_val(m, i);
    end
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  // send one vector built for map m; expected stream follows map m
  task automatic run_vector(input int m, input int fm, input bit tamper);
    int exp_port[ELEMS];
    int exp_data[ELEMS];
    int n_exp = 0;
    int ptr = 0;
    bit finished = 0;
    for (int i = 0; i < ELEMS; i++) begin
      if (!map_val(m, i)[2]) begin
        exp_port[n_exp] = int'(map_val(m, i)[1:0]);
        exp_data[n_exp] = int'(elem_val(m, fm, i));
        n_exp++;
      end
    end
    @(negedge clk);
    port_full = '0;
    vec_valid = 1'b1;
    for (int i = 0; i < ELEMS; i++) vec_data[i*DATA_W +: DATA_W] = elem_val(m, fm, i);
    if (tamper) begin
      cfg_we = 1'b1; cfg_idx = '0; cfg_entry = 3'b011;
    end
    #1;
    chk(vec_ready == 1'b1, "R7", "ready before accept", int'(vec_ready), 1);
    for (int k = 1; k <= 600 && !finished; k++) begin
      @(negedge clk);
      for (int p = 0; p < NPORTS; p++) port_full[p] = full_val(fm, k, p);
      vec_data = ~vec_data;  // junk offered while busy (R7)
      #1;
      chk(vec_ready == 1'b0, "R7", "ready while busy", int'(vec_ready), 0);
      chk($countones(port_push) <= 1, "R3", "pushes per cycle", $countones(port_push), 1);
      for (int p = 0; p < NPORTS; p++) begin
        if (port_push[p]) begin
          chk(!port_full[p], "R5", "push into full port", p, -1);
          if (ptr < n_exp) begin
            chk(p == exp_port[ptr], "R2", "push port", p, exp_port[ptr]);
            chk(int'(port_data) == exp_data[ptr], "R3", "push data",
                int'(port_data), exp_data[ptr]);
          end else begin
            chk(1'b0, "R4", "extra push", ptr, n_exp);
          end
          ptr++;
        end
      end
      if (vec_done) begin
        finished = 1;
        chk(ptr == n_exp, "R6", "pushes at done", ptr, n_exp);
        if (fm == 0) chk(k == ELEMS, "R4", "cycles to done", k, ELEMS);
      end
    end
    chk(finished, "R6", "done seen", int'(finished), 1);
    @(negedge clk);
    vec_valid = 1'b0;
    cfg_we    = 1'b0;
    port_full = '0;
    #1;
    chk(vec_ready == 1'b1, "R6", "ready after done", int'(vec_ready), 1);
    chk(vec_done == 1'b0, "R6", "done single cycle", int'(vec_done), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; cfg_we = 1'b0; cfg_idx = '0; cfg_entry = '0;
    vec_valid = 1'b0; vec_data = '0; port_full = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk(vec_ready == 1'b1, "R1", "ready after reset", int'(vec_ready), 1);
    chk(port_push == '0, "R1", "push after reset", int'(port_push), 0);
    chk(vec_done == 1'b0, "R1", "done after reset", int'(vec_done), 0);
    // R1: reset map is all skip, same as pattern 7
    run_vector(7, 0, 1'b0);

    // main sweep over maps and backpressure patterns (R2 R3 R4 R5 R6)
    for (int m = 0; m < 8; m++) begin
      for (int fm = 0; fm < 3; fm++) begin
        program_map(m);
        run_vector(m, fm, 1'b0);
      end
    end

    // R8: write in accept cycle and during walk is dropped
    program_map(0);
    run_vector(0, 1, 1'b1);
    run_vector(0, 0, 1'b0);
    run_vector(0, 2, 1'b1);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule